// File: doc/BRIEF.md
# Video Clock Divider Code Calculator

This block converts a requested video clock frequency and a reference clock frequency into the values a clock synthesizer needs when it is programmed directly. The requested frequency arrives as an integer count of quarter-megahertz units, and the reference frequency arrives in whole megahertz. The block places the request in one of four octave bands. Each band has its own step size and its own scaling rule. From the band it produces a 2-bit band code and a 6-bit VCO divide count, and it packs the two into one byte. From the reference frequency it produces a reference divider value.

A request goes in through a valid/ready handshake. The results are registered and appear one cycle after the request is accepted. They stay unchanged until the next request is accepted. Three flags mark a bad request:
- the frequency does not sit on its band's step grid;
- the frequency falls outside every band;
- the reference frequency is not supported.

When any of these flags is set, the response strobe still pulses, and a combined error bit marks the codes as unusable.

Top module: `vclk_divcalc`

## Requirements
- R1: A request Q (quarter-MHz units) selects band code 0 for Q in 65..128, code 1 for Q in 130..256, code 2 for Q in 260..512, and code 3 for Q in 520..880.
- R2: The divide count is (Q >> k) − 65, where k is 0, 1, 2 or 3 for band codes 0 to 3. The shift truncates.
- R3: The off-grid flag is set when the low k bits of Q are not all zero in an in-range request. An example is Q = 636 (159 MHz) in band 3. Q = 632 and Q = 640 are on the grid.
- R4: The out-of-range flag is set when Q is below 65, above 880, or in one of the gaps 129, 257..259 or 513..519. In that case the band code, the divide count and the off-grid flag are all 0.
- R5: A reference frequency R that is even and lies in 4..62 gives a reference divider of R/2. Any other R sets the bad-reference flag and gives a reference divider of 0.
- R6: The VCO byte carries the band code in bits 7:6 and the divide count in bits 5:0.
- R7: req_ready is 0 during reset and 1 afterwards. rsp_valid is high in the cycle after each accepted request, and low otherwise.
- R8: All result outputs and flags hold their values until the next accepted request, whatever the inputs do in between.
- R9: rsp_err equals the OR of the three flags. rsp_valid pulses whether or not rsp_err is set.
- R10: After reset, every output except req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_qmhz | input | 10 | Requested frequency in quarter-MHz units |
| req_ref_mhz | input | 7 | Reference frequency in MHz |
| rsp_valid | output | 1 | Result strobe, one cycle after acceptance |
| rsp_band | output | 2 | Band code |
| rsp_count | output | 6 | VCO divide count |
| rsp_vco_byte | output | 8 | Band code and count packed |
| rsp_refdiv | output | 5 | Reference divider value |
| rsp_off_grid | output | 1 | Frequency not on the band step |
| rsp_out_of_range | output | 1 | Frequency outside all bands |
| rsp_bad_ref | output | 1 | Reference frequency unsupported |
| rsp_err | output | 1 | Any flag set |

## Verification
The bound checker checks these rules on every cycle:
- the one-cycle response timing and the ready behaviour;
- that results are held between acceptances;
- that an out-of-range result has a zero band and count;
- that the error bit agrees with the flags;
- that on-grid band-2 requests give the expected count;
- that off-grid band-3 requests are flagged;
- that supported references give half their value.

Only the bench's sweeps can show the other results:
- the exact band edges;
- the gap codes;
- the truncated counts of off-grid requests;
- the full reference table, including the rejection of odd and out-of-span references.

// File: rtl/vclk_divcalc.sv
module vclk_divcalc #(
  parameter int QW   = 10,
  parameter int RW   = 7,
  parameter int CW   = 6,
  parameter int RDW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [QW-1:0]  req_qmhz,
  input  logic [RW-1:0]  req_ref_mhz,
  output logic           rsp_valid,
  output logic [1:0]     rsp_band,
  output logic [CW-1:0]  rsp_count,
  output logic [CW+1:0]  rsp_vco_byte,
  output logic [RDW-1:0] rsp_refdiv,
  output logic           rsp_off_grid,
  output logic           rsp_out_of_range,
  output logic           rsp_bad_ref,
  output logic           rsp_err
);

  localparam int BIAS    = 65;
  localparam int B0_LO   = BIAS;
  localparam int B0_HI   = 2 * BIAS - 2;
  localparam int B1_LO   = 2 * BIAS;
  localparam int B1_HI   = 4 * BIAS - 4;
  localparam int B2_LO   = 4 * BIAS;
  localparam int B2_HI   = 8 * BIAS - 8;
  localparam int B3_LO   = 8 * BIAS;
  localparam int B3_HI   = 880;
  localparam int REF_LO  = 4;
  localparam int REF_HI  = 62;

  logic            accept;
  logic [1:0]      band_c;
  logic            oor_c, grid_c, bad_c;
  logic [QW-1:0]   shq;
  logic [CW-1:0]   cnt_c;
  logic [RDW-1:0]  rdiv_c;
  logic [QW-1:0]   q;

  assign accept = req_valid & req_ready;
  assign q      = req_qmhz;

  always_comb begin
    band_c = 2'd0;
    oor_c  = 1'b0;
    if (q >= QW'(B0_LO) && q <= QW'(B0_HI))      band_c = 2'd0;
    else if (q >= QW'(B1_LO) && q <= QW'(B1_HI)) band_c = 2'd1;
    else if (q >= QW'(B2_LO) && q <= QW'(B2_HI)) band_c = 2'd2;
    else if (q >= QW'(B3_LO) && q <= QW'(B3_HI)) band_c = 2'd3;
    else                                          oor_c  = 1'b1;
  end

  always_comb begin
    shq    = q >> band_c;
    grid_c = 1'b0;
    case (band_c)
      2'd1:    grid_c = q[0] != 1'b0;
      2'd2:    grid_c = q[1:0] != 2'b00;
      2'd3:    grid_c = q[2:0] != 3'b000;
      default: grid_c = 1'b0;
    endcase
    cnt_c = CW'(shq - QW'(BIAS));
    if (oor_c) begin
      cnt_c  = '0;
      grid_c = 1'b0;
    end
  end

  always_comb begin
    bad_c  = req_ref_mhz[0] || req_ref_mhz < RW'(REF_LO) || req_ref_mhz > RW'(REF_HI);
    rdiv_c = bad_c ? '0 : RDW'(req_ref_mhz >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready        <= 1'b0;
      rsp_valid        <= 1'b0;
      rsp_band         <= '0;
      rsp_count        <= '0;
      rsp_refdiv       <= '0;
      rsp_off_grid     <= 1'b0;
      rsp_out_of_range <= 1'b0;
      rsp_bad_ref      <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_band         <= band_c;
        rsp_count        <= cnt_c;
        rsp_refdiv       <= rdiv_c;
        rsp_off_grid     <= grid_c;
        rsp_out_of_range <= oor_c;
        rsp_bad_ref      <= bad_c;
      end
    end
  end

  assign rsp_vco_byte = {rsp_band, rsp_count};
  assign rsp_err      = rsp_off_grid | rsp_out_of_range | rsp_bad_ref;

endmodule

module vclk_divcalc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [9:0] req_qmhz,
  input logic [6:0] req_ref_mhz,
  input logic       rsp_valid,
  input logic [1:0] rsp_band,
  input logic [5:0] rsp_count,
  input logic [4:0] rsp_refdiv,
  input logic       rsp_off_grid,
  input logic       rsp_out_of_range,
  input logic       rsp_bad_ref,
  input logic       rsp_err
);
  logic acc;
  assign acc = req_valid & req_ready;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid) else $error("rsp missing"); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid) else $error("spurious rsp"); // R7
  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && req_ready) |=> ($stable(rsp_band) && $stable(rsp_count) && $stable(rsp_refdiv)
      && $stable(rsp_off_grid) && $stable(rsp_out_of_range) && $stable(rsp_bad_ref)))
    else $error("results moved"); // R8
  AST_OOR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_out_of_range |-> (rsp_band == 2'd0 && rsp_count == 6'd0 && !rsp_off_grid))
    else $error("oor not zeroed"); // R4
  AST_ERR_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err == (rsp_off_grid || rsp_out_of_range || rsp_bad_ref))
    else $error("err mismatch"); // R9
  AST_BAND2_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_qmhz >= 10'd260 && req_qmhz <= 10'd512 && req_qmhz[1:0] == 2'b00)
      |=> (rsp_band == 2'd2 && 32'(rsp_count) == 32'($past(req_qmhz)) / 4 - 65))
    else $error("band2 count"); // R2
  AST_BAND3_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_qmhz >= 10'd520 && req_qmhz <= 10'd880 && req_qmhz[2:0] != 3'b000)
      |=> rsp_off_grid) else $error("band3 step"); // R3
  AST_REF_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_ref_mhz[0] && req_ref_mhz >= 7'd4 && req_ref_mhz <= 7'd62)
      |=> (!rsp_bad_ref && 7'(rsp_refdiv) == $past(req_ref_mhz) / 2))
    else $error("refdiv"); // R5
endmodule

bind vclk_divcalc vclk_divcalc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_qmhz(req_qmhz), .req_ref_mhz(req_ref_mhz), .rsp_valid(rsp_valid),
  .rsp_band(rsp_band), .rsp_count(rsp_count), .rsp_refdiv(rsp_refdiv),
  .rsp_off_grid(rsp_off_grid), .rsp_out_of_range(rsp_out_of_range),
  .rsp_bad_ref(rsp_bad_ref), .rsp_err(rsp_err)
);

// File: tb/sim_vclk_divcalc.sv
module sim_vclk_divcalc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [9:0] req_qmhz = '0;
  logic [6:0] req_ref_mhz = '0;
  logic       rsp_valid;
  logic [1:0] rsp_band;
  logic [5:0] rsp_count;
  logic [7:0] rsp_vco_byte;
  logic [4:0] rsp_refdiv;
  logic       rsp_off_grid, rsp_out_of_range, rsp_bad_ref, rsp_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vclk_divcalc u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_qmhz(req_qmhz), .req_ref_mhz(req_ref_mhz), .rsp_valid(rsp_valid),
    .rsp_band(rsp_band), .rsp_count(rsp_count), .rsp_vco_byte(rsp_vco_byte),
    .rsp_refdiv(rsp_refdiv), .rsp_off_grid(rsp_off_grid),
    .rsp_out_of_range(rsp_out_of_range), .rsp_bad_ref(rsp_bad_ref), .rsp_err(rsp_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input int q, input int r);
    int band, k, cnt, rdiv;
    bit oor, grid, bad;
    @(negedge clk);
    req_qmhz = 10'(q); req_ref_mhz = 7'(r); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    oor = 0; band = 0;
    if (q >= 65 && q <= 128) band = 0;
    else if (q >= 130 && q <= 256) band = 1;
    else if (q >= 260 && q <= 512) band = 2;
    else if (q >= 520 && q <= 880) band = 3;
    else oor = 1;
    k = band;
    grid = !oor && ((q & ((1 << k) - 1)) != 0);
    cnt = oor ? 0 : (((q >> k) - 65) & 63);
    bad = (r % 2 != 0) || r < 4 || r > 62;
    rdiv = bad ? 0 : r / 2;
    chk("R7 rsp_valid", int'(rsp_valid), 1);
    chk("R1 band", int'(rsp_band), band);
    chk("R2 count", int'(rsp_count), cnt);
    chk("R3 off_grid", int'(rsp_off_grid), int'(grid));
    chk("R4 out_of_range", int'(rsp_out_of_range), int'(oor));
    chk("R5 refdiv", int'(rsp_refdiv), rdiv);
    chk("R5 bad_ref", int'(rsp_bad_ref), int'(bad));
    chk("R6 vco_byte", int'(rsp_vco_byte), band * 64 + cnt);
    chk("R9 err", int'(rsp_err), int'(grid | oor | bad));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 ready in reset", int'(req_ready), 0);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 vco_byte", int'(rsp_vco_byte), 0);
    chk("R10 refdiv", int'(rsp_refdiv), 0);
    chk("R10 err", int'(rsp_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready after reset", int'(req_ready), 1);

    for (int q = 0; q < 1024; q++) request(q, 4 + 2 * (q % 30));
    for (int r = 0; r < 128; r++) request(640, r);
    request(636, 20);
    request(632, 20);

    request(300, 40);
    @(negedge clk);
    chk("R7 no second pulse", int'(rsp_valid), 0);
    for (int i = 0; i < 5; i++) begin
      req_qmhz = 10'(1000 - 7 * i); req_ref_mhz = 7'(3 + i);
      @(negedge clk);
      chk("R8 band held", int'(rsp_band), 2);
      chk("R8 count held", int'(rsp_count), 10);
      chk("R8 refdiv held", int'(rsp_refdiv), 20);
      chk("R8 flags held", int'(rsp_err), 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule